// File: doc/BRIEF.md
# Serial Flash Write-Protection and Status Controller

This block holds the status state of a small serial flash: two range-protection bits, a lock bit, a write-enable flag and a busy flag. The command front-end sends it one decoded instruction strobe at a time. It carries an opcode, a target address and, for a status write, a data byte. For every program or erase request the block answers one cycle later with a verdict pulse, grant or deny. A granted operation sets busy, and busy stays set until the array sequencer reports completion.

Protection always covers the top of the array. A lock bit guards the status register, but only while the active-low hardware protect pin is held low. The status register can be rewritten only by a write issued as the instruction directly after a status-write enable. A quarter-array protection setting does not stop a block erase. A chip erase is refused if any region is protected. The status byte is always presented on `status_o` for a read-status instruction.

Top module: `flash_prot_ctrl`

## Requirements
- R1: After reset, `status_o` is 8'h0C (both range bits set, lock, write-enable and busy clear) and `grant_valid_o` is 0.
- R2: Status byte layout: bit0 busy, bit1 write-enable, bit2 range bit 0, bit3 range bit 1, bit7 lock. Bits 6:4 always read 0. A status write takes its new values from the same bit positions of `wr_data_i`.
- R3: Opcode 1 sets write-enable and opcode 2 clears it. Any program or erase request made while not busy also clears write-enable.
- R4: For program (opcode 5) and sector erase (opcode 6), the protected range depends on bits {3,2}. 00 protects nothing, 01 protects 'hC000-'hFFFF, 10 protects 'h8000-'hFFFF, 11 protects all of 'h0000-'hFFFF.
- R5: Block erase (opcode 7) follows R4, except that range setting 01 protects nothing.
- R6: Chip erase (opcode 8) is granted only when both range bits are 0.
- R7: Each program or erase request gives `grant_valid_o`=1 on the cycle after it. `grant_o` is 1 only if write-enable was set, busy was clear and the target was unprotected.
- R8: A grant sets busy together with the verdict, and busy stays 1 until `op_done_i` is seen.
- R9: A status write (opcode 4) takes effect only when the instruction directly before it was the status-write enable (opcode 3). Any other instruction in between, read-status (opcode 9) included, cancels the enable.
- R10: While lock is 1 and `wp_ni` is low, status writes are ignored. While `wp_ni` is high, lock has no effect.
- R11: A status write never changes the busy or write-enable bits.
- R12: While busy, no instruction changes write-enable, the range bits or lock, and program or erase requests are denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | One-cycle strobe for a decoded instruction |
| cmd_op_i | input | 4 | Opcode (encodings as given in the requirements) |
| addr_i | input | 16 | Target byte address for program or erase |
| wr_data_i | input | 8 | Data byte for a status write |
| wp_ni | input | 1 | Hardware protect pin, active low |
| op_done_i | input | 1 | Array operation finished, clears busy |
| status_o | output | 8 | Status byte |
| grant_valid_o | output | 1 | Verdict strobe for a program or erase request |
| grant_o | output | 1 | Verdict: 1 allow, 0 deny |

## Verification
The bench sweeps every range setting against all four program and erase kinds, at addresses spread across the array and at the exact 'h7FFF/'h8000 and 'hBFFF/'hC000 edges. A design that swapped the range codes, applied the quarter setting to block erase, or let chip erase through under partial protection would grant a request the bench expects denied. Other sequences cover a status write separated from its enable by a read-status, a lock held by the pin and then released by raising it, and status writes that try to set busy or write-enable. A design that armed the enable too long, ignored the pin, or let such data through would show a wrong status byte. Commands issued while busy must leave every flag as it was.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  typedef enum logic [3:0] {
    CMD_NONE  = 4'd0,
    CMD_WREN  = 4'd1,
    CMD_WRDI  = 4'd2,
    CMD_EWSR  = 4'd3,
    CMD_WRSR  = 4'd4,
    CMD_PROG  = 4'd5,
    CMD_SECT  = 4'd6,
    CMD_BLOCK = 4'd7,
    CMD_CHIP  = 4'd8,
    CMD_RDSR  = 4'd9,
    CMD_OTHER = 4'd10
  } cmd_e;

  localparam int unsigned SB_BUSY = 0;
  localparam int unsigned SB_WEL  = 1;
  localparam int unsigned SB_BP0  = 2;
  localparam int unsigned SB_BP1  = 3;
  localparam int unsigned SB_LOCK = 7;

  function automatic logic is_pe(input cmd_e op);
    return (op == CMD_PROG) || (op == CMD_SECT) || (op == CMD_BLOCK) || (op == CMD_CHIP);
  endfunction
endpackage

// File: rtl/flash_prot_range.sv
module flash_prot_range
  import flash_prot_pkg::*;
(
  input  logic [1:0] bp_i,
  input  cmd_e       op_i,
  input  logic [1:0] addr_top_i,   // two MSBs of the target address
  output logic       hit_o
);
  always_comb begin
    unique case (bp_i)
      2'b00: hit_o = 1'b0;
      // quarter level: block erase exempt
      2'b01: hit_o = (op_i == CMD_CHIP) ||
                     ((op_i != CMD_BLOCK) && (addr_top_i == 2'b11));
      2'b10: hit_o = (op_i == CMD_CHIP) || addr_top_i[1];
      default: hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/flash_prot_sreg.sv
module flash_prot_sreg
  import flash_prot_pkg::*;
#(
  parameter logic [1:0] BP_RST = 2'b11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  cmd_e       op_i,
  input  logic [7:0] wr_data_i,
  input  logic       wp_ni,
  input  logic       busy_i,
  output logic [1:0] bp_o,
  output logic       lock_o,
  output logic       armed_o
);
  logic wr_ok;
  logic unused_data;

  assign unused_data = ^{wr_data_i[6:4], wr_data_i[1:0]};
  assign wr_ok = cmd_valid_i && (op_i == CMD_WRSR) && armed_o && !busy_i &&
                 !(lock_o && !wp_ni);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_o    <= BP_RST;
      lock_o  <= 1'b0;
      armed_o <= 1'b0;
    end else begin
      if (cmd_valid_i) armed_o <= (op_i == CMD_EWSR) && !busy_i;
      if (wr_ok) begin
        bp_o   <= {wr_data_i[SB_BP1], wr_data_i[SB_BP0]};
        lock_o <= wr_data_i[SB_LOCK];
      end
    end
  end
endmodule

// File: rtl/flash_prot_gate.sv
module flash_prot_gate
  import flash_prot_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  cmd_e op_i,
  input  logic hit_i,
  input  logic op_done_i,
  output logic wel_o,
  output logic busy_o,
  output logic grant_valid_o,
  output logic grant_o
);
  logic pe_req, pe_ok;

  assign pe_req = cmd_valid_i && is_pe(op_i);
  assign pe_ok  = pe_req && !busy_o && wel_o && !hit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_o         <= 1'b0;
      busy_o        <= 1'b0;
      grant_valid_o <= 1'b0;
      grant_o       <= 1'b0;
    end else begin
      grant_valid_o <= pe_req;
      grant_o       <= pe_ok;
      if (pe_ok)          busy_o <= 1'b1;
      else if (op_done_i) busy_o <= 1'b0;
      if (cmd_valid_i && !busy_o) begin
        if (op_i == CMD_WREN)               wel_o <= 1'b1;
        else if (op_i == CMD_WRDI || pe_req) wel_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/flash_prot_ctrl.sv
module flash_prot_ctrl
  import flash_prot_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              wp_ni,
  input  logic              op_done_i,
  output logic [7:0]        status_o,
  output logic              grant_valid_o,
  output logic              grant_o
);
  cmd_e       op;
  logic [1:0] bp;
  logic       lock, wel, busy, hit, ewsr_armed;
  logic       unused_addr;

  assign op = cmd_e'(cmd_op_i);
  assign unused_addr = ^addr_i[ADDR_W-3:0];

  flash_prot_range u_range (
    .bp_i       (bp),
    .op_i       (op),
    .addr_top_i (addr_i[ADDR_W-1:ADDR_W-2]),
    .hit_o      (hit)
  );

  flash_prot_sreg u_sreg (
    .clk_i, .rst_ni, .cmd_valid_i,
    .op_i      (op),
    .wr_data_i,
    .wp_ni,
    .busy_i    (busy),
    .bp_o      (bp),
    .lock_o    (lock),
    .armed_o   (ewsr_armed)
  );

  flash_prot_gate u_gate (
    .clk_i, .rst_ni, .cmd_valid_i,
    .op_i          (op),
    .hit_i         (hit),
    .op_done_i,
    .wel_o         (wel),
    .busy_o        (busy),
    .grant_valid_o,
    .grant_o
  );

  always_comb begin
    status_o          = '0;
    status_o[SB_BUSY] = busy;
    status_o[SB_WEL]  = wel;
    status_o[SB_BP0]  = bp[0];
    status_o[SB_BP1]  = bp[1];
    status_o[SB_LOCK] = lock;
  end
endmodule

// File: rtl/flash_prot_chk.sv
module flash_prot_chk
  import flash_prot_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_valid_i,
  input logic [3:0] cmd_op_i,
  input logic       wp_ni,
  input logic       op_done_i,
  input logic [7:0] status_o,
  input logic       grant_valid_o,
  input logic       grant_o,
  input logic       ewsr_armed
);
  logic is_wrsr, is_req;
  assign is_wrsr = cmd_valid_i && (cmd_op_i == 4'(CMD_WRSR));
  assign is_req  = cmd_valid_i && is_pe(cmd_e'(cmd_op_i));

  assert_unused_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6:4] == 3'b000);
  assert_no_wel_deny_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_req && !status_o[1] |=> grant_valid_o && !grant_o);
  assert_chip_partial_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && (cmd_op_i == 4'(CMD_CHIP)) && (status_o[3:2] != 2'b00) |=> !grant_o);
  assert_grant_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o && grant_o |-> status_o[0]);
  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] && !op_done_i |=> status_o[0]);
  assert_unarmed_wrsr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wrsr && !ewsr_armed |=> $stable(status_o[7:2]));
  assert_pin_lock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wrsr && status_o[7] && !wp_ni |=> $stable(status_o[7:2]));
  assert_flags_kept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_wrsr && !op_done_i |=> $stable(status_o[1:0]));
endmodule

bind flash_prot_ctrl flash_prot_chk u_chk (.*);

// File: tb/flash_prot_ctrl_test.sv
`timescale 1ns/1ps
module flash_prot_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic [15:0] addr = 16'h0;
  logic [7:0]  wdata = 8'h0;
  logic        wp_n = 1'b1;
  logic        op_done = 1'b0;
  logic [7:0]  status;
  logic        gvalid, grant;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  flash_prot_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op),
    .addr_i(addr), .wr_data_i(wdata), .wp_ni(wp_n), .op_done_i(op_done),
    .status_o(status), .grant_valid_o(gvalid), .grant_o(grant)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive on negedge, return at next negedge (one posedge consumed)
  task automatic issue(input logic [3:0] op, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; addr = a; wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic done_pulse();
    @(negedge clk); op_done = 1'b1;
    @(negedge clk); op_done = 1'b0;
  endtask

  task automatic set_sr(input logic [7:0] d);
    issue(4'd3, 16'h0, 8'h0);
    issue(4'd4, 16'h0, d);
  endtask

  function automatic logic prot(input logic [1:0] bp, input logic [3:0] op, input logic [15:0] a);
    case (bp)
      2'd0: return 1'b0;
      2'd1: return (op == 4'd8) ? 1'b1 : (op == 4'd7) ? 1'b0 : (a >= 16'hC000);
      2'd2: return (op == 4'd8) ? 1'b1 : (a >= 16'h8000);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] addr_at(input int i);
    case (i)
      16: return 16'h7FFF;
      17: return 16'h8000;
      18: return 16'hBFFF;
      19: return 16'hC000;
      default: return 16'(i * 16'h1000 + ((i * 16'h137) & 16'h0FFF));
    endcase
  endfunction

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 status", status, 8'h0C);
    chk("R1 grant_valid", gvalid, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    issue(4'd1, 16'h0, 8'h0);
    chk("R3 wren", status, 8'h0E);
    issue(4'd2, 16'h0, 8'h0);
    chk("R3 wrdi", status, 8'h0C);

    issue(4'd1, 16'h0, 8'h0);
    issue(4'd5, 16'h0000, 8'h0);
    chk("R4 full-protect deny", {gvalid, grant}, 2'b10);
    chk("R3 wel cleared by request", status, 8'h0C);

    set_sr(8'h00);
    chk("R9 armed write", status, 8'h00);
    issue(4'd5, 16'h1234, 8'h0);
    chk("R7 no wel deny", {gvalid, grant}, 2'b10);

    // protection sweep
    for (int bp = 0; bp < 4; bp++) begin
      set_sr(8'(bp << 2));
      chk("R9 sweep setup", status, 8'(bp << 2));
      for (int k = 0; k < 4; k++) begin
        for (int i = 0; i < 20; i++) begin
          logic [3:0] op;
          logic [15:0] a;
          logic p;
          op = 4'(5 + k);
          a  = addr_at(i);
          p  = prot(2'(bp), op, a);
          issue(4'd1, 16'h0, 8'h0);
          issue(op, a, 8'h0);
          if (k == 1) chk("R4 sector", {gvalid, grant}, {1'b1, !p});
          else if (k == 2) chk("R5 block", {gvalid, grant}, {1'b1, !p});
          else if (k == 3) chk("R6 chip", {gvalid, grant}, {1'b1, !p});
          else chk("R4 program", {gvalid, grant}, {1'b1, !p});
          chk("R8 busy with grant", status, 8'((bp << 2) | (p ? 0 : 1)));
          if (!p) begin
            done_pulse();
            chk("R8 busy cleared", status, 8'(bp << 2));
          end
        end
      end
    end

    // busy window
    set_sr(8'h00);
    issue(4'd1, 16'h0, 8'h0);
    issue(4'd5, 16'h0100, 8'h0);
    chk("R8 granted", {gvalid, grant}, 2'b11);
    repeat (5) @(negedge clk);
    chk("R8 busy held", status, 8'h01);
    issue(4'd1, 16'h0, 8'h0);
    chk("R12 wren while busy", status, 8'h01);
    set_sr(8'h8C);
    chk("R12 status write while busy", status, 8'h01);
    issue(4'd5, 16'h0200, 8'h0);
    chk("R12 request while busy", {gvalid, grant}, 2'b10);
    done_pulse();
    chk("R8 done", status, 8'h00);

    // arming
    issue(4'd4, 16'h0, 8'h0C);
    chk("R9 unarmed write", status, 8'h00);
    issue(4'd3, 16'h0, 8'h0);
    issue(4'd9, 16'h0, 8'h0);
    issue(4'd4, 16'h0, 8'h0C);
    chk("R9 cancelled by read-status", status, 8'h00);
    issue(4'd3, 16'h0, 8'h0);
    issue(4'd10, 16'h0, 8'h0);
    issue(4'd4, 16'h0, 8'h0C);
    chk("R9 cancelled by other", status, 8'h00);
    set_sr(8'h04);
    chk("R9 armed", status, 8'h04);

    set_sr(8'h83);
    chk("R11 flags not written", status, 8'h80);
    set_sr(8'hF0);
    chk("R2 unused bits", status, 8'h80);

    // pin lock
    wp_n = 1'b0;
    set_sr(8'h0C);
    chk("R10 locked", status, 8'h80);
    wp_n = 1'b1;
    set_sr(8'h88);
    chk("R10 pin high", status, 8'h88);
    wp_n = 1'b0;
    set_sr(8'h00);
    chk("R10 relocked", status, 8'h88);
    wp_n = 1'b1;

    issue(4'd1, 16'h0, 8'h0);
    set_sr(8'h00);
    chk("R11 wel kept", status, 8'h02);
    issue(4'd8, 16'h0, 8'h0);
    chk("R6 chip open", {gvalid, grant}, 2'b11);
    done_pulse();
    chk("R8 final idle", status, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule